// File: doc/BRIEF.md
# H-Bridge PWM Output Steering Channel

This block is one channel of a motor-drive PWM output stage. It owns two output pins, a plus pin and a minus pin, and drives each one with a data bit and an output-enable bit. A free-running period counter is compared against a duty magnitude to form a PWM waveform. The block steers that waveform onto one pin, and it either drives the other pin to a static level or releases it so that other logic can use it.

A small write port loads two registers. The control register holds a 2-bit mode and a recirculation bit. The duty register holds a magnitude and a sign bit. The modes are off, half bridge, full bridge and paired full bridge. In half-bridge mode only the plus pin is used. In the two full-bridge modes the sign picks the pin that carries the PWM, and the recirculation bit sets the static level of the other pin. A new duty value takes effect only at a period boundary, so no pulse is ever cut short. In paired mode the two channels of a pair share one load. Each channel then also waits for a pair commit strobe before it accepts a new duty value, so both channels switch in the same period.

Top module: `hbridge_pwm_chan`

## Requirements
- R1: While reset is asserted, and in the cycles after it until a mode is written, both output enables and both data outputs are 0.
- R2: In mode 2'b00 (off), both pins are released: output enable 0 and data 0, whatever duty value is held.
- R3: In mode 2'b01 (half bridge), the plus pin is enabled and carries the PWM active-high. The minus pin is released (enable 0, data 0). The sign and recirculation bits have no effect in this mode.
- R4: In mode 2'b10 (full bridge), both pins are enabled. Sign 0 puts the PWM on the plus pin and sign 1 puts it on the minus pin.
- R5: In either full-bridge mode, the pin that does not carry the PWM is driven to the recirculation bit. When that bit is 1, the PWM is inverted (its active level is low).
- R6: The period counter runs 0 to PERIOD-1 and starts at 0 after reset. The PWM is active while the counter is below the magnitude. A magnitude of 0 is never active, and a magnitude of PERIOD or more is always active.
- R7: A written magnitude and sign take effect in the cycle after the counter passes from PERIOD-1 to 0. A written mode and recirculation bit take effect in the cycle after the write.
- R8: In mode 2'b11 (paired full bridge), the pins behave as in R4 and R5. A pending duty value is taken at a period boundary only if pair_commit is high in the last cycle of the period.
- R9: Write port encoding. With wr_sel = 0, wr_data[1:0] is the mode and wr_data[2] is the recirculation bit. With wr_sel = 1, wr_data[MAG_W-1:0] is the magnitude and wr_data[MAG_W] is the sign.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the control register, 1 selects the duty register |
| wr_data | input | MAG_W+1 | Write data |
| pair_commit | input | 1 | Paired-mode strobe that lets a pending duty value load at the period boundary |
| plus_o | output | 1 | Plus pin data |
| plus_oe | output | 1 | Plus pin output enable |
| minus_o | output | 1 | Minus pin data |
| minus_oe | output | 1 | Minus pin output enable |

## Verification
The assertions check every cycle that the off and half-bridge modes release the right pins. In the full-bridge modes they check that one pin always sits at the recirculation level. They also check that the active duty value never changes in the middle of a period, that paired mode holds it back without a commit, and that a zero magnitude gives no pulse. Only the bench's reference model shows the exact PWM waveform for each magnitude, the sign steering and its inversion, and the cycle on which a written value first appears. The same holds for the saturated magnitude, for duty writes made in the middle of a period, and for a commit that arrives several periods late.

// File: rtl/hbridge_pwm_chan.sv
module hbridge_pwm_chan #(
  parameter int PERIOD = 16,
  parameter int MAG_W  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [MAG_W:0]   wr_data,
  input  logic             pair_commit,
  output logic             plus_o,
  output logic             plus_oe,
  output logic             minus_o,
  output logic             minus_oe
);
  localparam int CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam int XW = (CW > MAG_W) ? CW : MAG_W;
  localparam logic [1:0] M_OFF  = 2'b00;
  localparam logic [1:0] M_HALF = 2'b01;
  localparam logic [1:0] M_DUAL = 2'b11;

  logic [1:0]       mode_q;
  logic             recirc_q;
  logic [CW-1:0]    cnt_q;
  logic [MAG_W-1:0] pend_mag_q, act_mag_q;
  logic             pend_sign_q, act_sign_q;

  wire wrap = (cnt_q == CW'(PERIOD - 1));
  wire load = wrap && ((mode_q != M_DUAL) || pair_commit);
  wire pwm  = XW'(cnt_q) < XW'(act_mag_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q       <= '0;
      mode_q      <= M_OFF;
      recirc_q    <= 1'b0;
      pend_mag_q  <= '0;
      pend_sign_q <= 1'b0;
      act_mag_q   <= '0;
      act_sign_q  <= 1'b0;
    end else begin
      cnt_q <= wrap ? '0 : cnt_q + 1'b1;
      if (wr_en && !wr_sel) begin
        mode_q   <= wr_data[1:0];
        recirc_q <= wr_data[2];
      end
      if (wr_en && wr_sel) begin
        pend_mag_q  <= wr_data[MAG_W-1:0];
        pend_sign_q <= wr_data[MAG_W];
      end
      if (load) begin
        act_mag_q  <= pend_mag_q;
        act_sign_q <= pend_sign_q;
      end
    end
  end

  wire drv = pwm ^ recirc_q;

  always_comb begin
    plus_o   = 1'b0;
    plus_oe  = 1'b0;
    minus_o  = 1'b0;
    minus_oe = 1'b0;
    case (mode_q)
      M_OFF: ;
      M_HALF: begin
        plus_oe = 1'b1;
        plus_o  = pwm;
      end
      default: begin
        plus_oe  = 1'b1;
        minus_oe = 1'b1;
        plus_o   = act_sign_q ? recirc_q : drv;
        minus_o  = act_sign_q ? drv : recirc_q;
      end
    endcase
  end
endmodule

module hbridge_pwm_chan_chk #(
  parameter int CW    = 4,
  parameter int MAG_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pair_commit,
  input logic [1:0]       mode_q,
  input logic             recirc_q,
  input logic [CW-1:0]    cnt_q,
  input logic [MAG_W-1:0] act_mag_q,
  input logic             act_sign_q,
  input logic             plus_o,
  input logic             plus_oe,
  input logic             minus_o,
  input logic             minus_oe
);
  a_r1_reset_released: assert property (@(posedge clk)
    !rst_n |=> (!plus_oe && !minus_oe && !plus_o && !minus_o));

  a_r2_off_released: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'b00) |-> (!plus_oe && !minus_oe));

  a_r3_half_minus_free: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'b01) |-> (plus_oe && !minus_oe && !minus_o));

  a_r5_static_pin: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q[1] |-> (plus_oe && minus_oe && (plus_o == recirc_q || minus_o == recirc_q)));

  a_r6_zero_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'b01 && act_mag_q == '0) |-> !plus_o);

  a_r7_no_midperiod_change: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |-> ($stable(act_mag_q) && $stable(act_sign_q)));

  a_r8_dual_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && mode_q == 2'b11 && $past(mode_q) == 2'b11 && !$past(pair_commit))
      |-> ($stable(act_mag_q) && $stable(act_sign_q)));
endmodule

bind hbridge_pwm_chan hbridge_pwm_chan_chk #(.CW(CW), .MAG_W(MAG_W)) u_chk (.*);

// File: tb/hbridge_pwm_chan_tb.sv
`timescale 1ns/1ps
module hbridge_pwm_chan_tb;
  localparam int PERIOD = 16;
  localparam int MAG_W  = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, wr_sel = 1'b0, pair_commit = 1'b0;
  logic [MAG_W:0] wr_data = '0;
  logic plus_o, plus_oe, minus_o, minus_oe;

  int checks = 0, fails = 0;
  string cur_req = "R1";
  bit cmp_on = 1'b0;

  int m_cnt, m_mode, m_recirc, m_pmag, m_psign, m_amag, m_asign;

  always #4 clk = ~clk;

  hbridge_pwm_chan #(.PERIOD(PERIOD), .MAG_W(MAG_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .pair_commit(pair_commit), .plus_o(plus_o), .plus_oe(plus_oe),
    .minus_o(minus_o), .minus_oe(minus_oe));

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= 0; m_mode <= 0; m_recirc <= 0;
      m_pmag <= 0; m_psign <= 0; m_amag <= 0; m_asign <= 0;
    end else begin
      m_cnt <= (m_cnt == PERIOD - 1) ? 0 : m_cnt + 1;
      if (wr_en && !wr_sel) begin
        m_mode <= int'(wr_data[1:0]); m_recirc <= int'(wr_data[2]);
      end
      if (wr_en && wr_sel) begin
        m_pmag <= int'(wr_data[MAG_W-1:0]); m_psign <= int'(wr_data[MAG_W]);
      end
      if (m_cnt == PERIOD - 1 && (m_mode != 3 || pair_commit)) begin
        m_amag <= m_pmag; m_asign <= m_psign;
      end
    end
  end

  task automatic compare(input string req);
    logic [3:0] exp, act;
    logic p;
    p = (m_cnt < m_amag);
    case (m_mode)
      0: exp = 4'b0000;
      1: exp = {p, 1'b1, 1'b0, 1'b0};
      default: begin
        logic d, r;
        r = m_recirc[0];
        d = p ^ r;
        exp = m_asign[0] ? {r, 1'b1, d, 1'b1} : {d, 1'b1, r, 1'b1};
      end
    endcase
    act = {plus_o, plus_oe, minus_o, minus_oe};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cnt=%0d {p,poe,m,moe} actual=%b expected=%b", req, m_cnt, act, exp);
    end
  endtask

  always @(negedge clk) if (cmp_on && rst_n) compare(cur_req);

  task automatic wr(input logic sel, input logic [MAG_W:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait_cyc(3);
    cur_req = "R1";
    compare("R1");
    rst_n = 1'b1;
    cmp_on = 1'b1;
    wait_cyc(5);
    cur_req = "R2";
    wr(1'b1, {1'b0, 5'd5});
    wait_cyc(2 * PERIOD);
    cur_req = "R3";
    wr(1'b0, 6'b000_101);
    wait_cyc(2 * PERIOD);
    wr(1'b1, {1'b1, 5'd9});
    wait_cyc(2 * PERIOD);
    cur_req = "R4_R9";
    wr(1'b0, 6'b000_010);
    wr(1'b1, {1'b0, 5'd4});
    wait_cyc(2 * PERIOD);
    wr(1'b1, {1'b1, 5'd11});
    wait_cyc(2 * PERIOD);
    cur_req = "R5";
    wr(1'b0, 6'b000_110);
    wait_cyc(2 * PERIOD);
    wr(1'b1, {1'b0, 5'd3});
    wait_cyc(2 * PERIOD);
    cur_req = "R6";
    wr(1'b1, {1'b0, 5'd0});
    wait_cyc(2 * PERIOD);
    wr(1'b1, {1'b1, 5'd16});
    wait_cyc(2 * PERIOD);
    wr(1'b1, {1'b0, 5'd31});
    wait_cyc(2 * PERIOD);
    wr(1'b0, 6'b000_001);
    wr(1'b1, {1'b0, 5'd0});
    wait_cyc(2 * PERIOD);
    cur_req = "R7";
    wr(1'b0, 6'b000_010);
    for (int k = 0; k < 6; k++) begin
      wait_cyc(k + 3);
      wr(1'b1, {k[0], 5'(2 * k + 1)});
    end
    wait_cyc(2 * PERIOD);
    cur_req = "R8";
    pair_commit = 1'b0;
    wr(1'b0, 6'b000_011);
    wr(1'b1, {1'b1, 5'd7});
    wait_cyc(3 * PERIOD);
    pair_commit = 1'b1;
    wait_cyc(2 * PERIOD);
    pair_commit = 1'b0;
    wr(1'b0, 6'b000_111);
    wr(1'b1, {1'b0, 5'd12});
    wait_cyc(2 * PERIOD);
    pair_commit = 1'b1;
    wait_cyc(2 * PERIOD);
    cur_req = "R2";
    wr(1'b0, 6'b000_000);
    wait_cyc(PERIOD);
    cmp_on = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule